// File: doc/BRIEF.md
# Shared-Channel DMA Completion Interrupt Logic

This block sits on the device side of one fly-by DMA channel. It raises the channel request line once for each byte the device has ready. It watches the channel acknowledge and the terminal-count strobe, and it holds an interrupt for software when its own buffer is finished. The terminal-count strobe is common to every channel, so the block honours it only when the strobe arrives together with an acknowledge that the block itself asked for.

Software arms the block with a start pulse and can cancel it with an abort pulse. While the block is not armed, it drops the output enable of its request line, so other devices can drive the same channel. An optional early-warning counter can be loaded with a value smaller than the DMA count. The interrupt then fires some transfers before the DMA runs dry, which leaves software time to reprogram the controller.

Top module: `dma_periph_irq`

## Requirements
- R1: After reset, `drq`, `drq_oe`, `irq` and `data_move` are all low.
- R2: A `sw_start` pulse arms the block, and `drq_oe` is high from the next cycle. A `sw_abort` pulse disarms it from the next cycle and wins over a simultaneous start. Whenever `drq_oe` is low, `drq` is low and `xfer_ready` has no effect.
- R3: While armed, `drq` rises in the cycle after `xfer_ready` is sampled high. It stays high while `dack_n` stays high, and it falls in the cycle after a valid acknowledge, giving one request per byte.
- R4: A valid acknowledge is `dack_n` low while the block is armed and `drq` is high. `data_move` is high in that same cycle and only then. Any other low `dack_n` moves no data and changes nothing.
- R5: `tc` high together with a valid acknowledge sets `irq` and disarms the block (`drq_oe` low), both from the next cycle. `tc` without a valid acknowledge is ignored.
- R6: `cnt_load` loads `cnt_value` into the early-warning counter. Each valid acknowledge decrements the counter, which stops at zero. A valid acknowledge while the counter holds 1 sets `irq` from the next cycle. A loaded value of 0 never raises `irq`.
- R7: `irq` stays high until an `irq_ack` pulse clears it. When a set condition and `irq_ack` fall in the same cycle, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_ready | input | 1 | Device has a byte ready to transfer |
| dack_n | input | 1 | Channel acknowledge, active low |
| tc | input | 1 | Shared terminal-count strobe |
| sw_start | input | 1 | Software arm pulse |
| sw_abort | input | 1 | Software abort pulse |
| cnt_load | input | 1 | Load the early-warning counter |
| cnt_value | input | CNT_W | Early-warning count, 0 disables |
| irq_ack | input | 1 | Software interrupt acknowledge |
| drq | output | 1 | Channel request |
| drq_oe | output | 1 | Output enable for the request line (low means high impedance) |
| irq | output | 1 | Interrupt request |
| data_move | output | 1 | Data path enable for the current acknowledge |

## Verification
The main sweep pairs every early-warning count from 0 to 6 with every DMA buffer length from 1 to 7. The interrupt should first appear after the smaller of the two lengths, or only at terminal count when the early count is 0 or larger than the buffer. These pairs separate a counter that fires early or late, a counter that fails to stop at zero, and terminal-count handling that is broken. Directed patterns add several cases: a stray acknowledge or terminal-count strobe while idle or while no request is pending, a request held through cycles with no acknowledge, a start and an abort in the same cycle, and an acknowledge that arrives together with a new set condition.

// File: rtl/dmairq_pkg.sv
`timescale 1ns/1ps
package dmairq_pkg;
   // One cycle's view of the channel acknowledge as seen by this device
   typedef struct packed {
      logic valid;   // acknowledge matches a pending request of ours
      logic term;    // that acknowledge also carries terminal count
   } ack_ev_t;
endpackage

// File: rtl/dmairq_req.sv
`timescale 1ns/1ps
module dmairq_req
   import dmairq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    xfer_ready,
   input  logic    dack_n,
   input  logic    tc,
   input  logic    sw_start,
   input  logic    sw_abort,
   output logic    armed,
   output logic    req,
   output ack_ev_t ev
);
   logic armed_q, req_q;

   always_comb begin
      ev.valid = ~dack_n & req_q & armed_q;
      ev.term  = ev.valid & tc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         if (sw_abort || ev.term)  armed_q <= 1'b0;
         else if (sw_start)        armed_q <= 1'b1;

         if (!armed_q || sw_abort || ev.term || ev.valid) req_q <= 1'b0;
         else if (xfer_ready)                             req_q <= 1'b1;
      end
   end

   assign armed = armed_q;
   assign req   = req_q;
endmodule

// File: rtl/dmairq_early.sv
`timescale 1ns/1ps
module dmairq_early #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             hit,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt_q;

   assign hit = dec && !load && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= load_val;
      else if (dec && cnt_q != '0)     cnt_q <= cnt_q - ONE;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/dmairq_latch.sv
`timescale 1ns/1ps
module dmairq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end
endmodule

// File: rtl/dma_periph_irq.sv
`timescale 1ns/1ps
module dma_periph_irq
   import dmairq_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit EARLY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_ready,
   input  logic             dack_n,
   input  logic             tc,
   input  logic             sw_start,
   input  logic             sw_abort,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_value,
   input  logic             irq_ack,
   output logic             drq,
   output logic             drq_oe,
   output logic             irq,
   output logic             data_move
);
   if (CNT_W < 2) begin : g_bad_width
      $error("dma_periph_irq: CNT_W must be at least 2");
   end

   ack_ev_t          ev;
   logic             armed;
   logic             early_hit;
   logic [CNT_W-1:0] early_cnt;

   dmairq_req u_req (
      .clk(clk), .rst_n(rst_n), .xfer_ready(xfer_ready), .dack_n(dack_n),
      .tc(tc), .sw_start(sw_start), .sw_abort(sw_abort),
      .armed(armed), .req(drq), .ev(ev)
   );

   if (EARLY_EN) begin : g_early
      dmairq_early #(.CNT_W(CNT_W)) u_early (
         .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_value),
         .dec(ev.valid), .hit(early_hit), .cnt(early_cnt)
      );
   end else begin : g_no_early
      logic unused_ok;
      assign unused_ok = &{1'b0, cnt_load, cnt_value};
      assign early_hit = 1'b0;
      assign early_cnt = '0;
   end

   dmairq_latch u_irq (
      .clk(clk), .rst_n(rst_n), .set(ev.term | early_hit), .clr(irq_ack),
      .flag(irq)
   );

   assign drq_oe    = armed;
   assign data_move = ev.valid;
endmodule

// File: rtl/dma_periph_irq_chk.sv
`timescale 1ns/1ps
module dma_periph_irq_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dack_n,
   input logic             tc,
   input logic             sw_abort,
   input logic             cnt_load,
   input logic             irq_ack,
   input logic             drq,
   input logic             drq_oe,
   input logic             irq,
   input logic             data_move,
   input logic [CNT_W-1:0] early_cnt
);
   // R2
   req_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drq |-> drq_oe);
   // R3
   req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && dack_n && !sw_abort) |=> drq);
   // R3
   req_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && !dack_n) |=> !drq);
   // R4
   stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dack_n || !drq) |-> !data_move);
   // R5
   tc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && !dack_n && tc) |=> (irq && !drq_oe));
   // R6
   early_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_move && !cnt_load && early_cnt == CNT_W'(1)) |=> irq);
   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);
endmodule

bind dma_periph_irq dma_periph_irq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dack_n(dack_n), .tc(tc), .sw_abort(sw_abort),
   .cnt_load(cnt_load), .irq_ack(irq_ack), .drq(drq), .drq_oe(drq_oe),
   .irq(irq), .data_move(data_move), .early_cnt(early_cnt)
);

// File: tb/tb_dma_periph_irq.sv
`timescale 1ns/1ps
module tb_dma_periph_irq;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xfer_ready = 0, dack_n = 1, tc = 0, sw_start = 0, sw_abort = 0;
   logic cnt_load = 0, irq_ack = 0;
   logic [CW-1:0] cnt_value = '0;
   logic drq, drq_oe, irq, data_move;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dma_periph_irq #(.CNT_W(CW), .EARLY_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .xfer_ready(xfer_ready), .dack_n(dack_n),
      .tc(tc), .sw_start(sw_start), .sw_abort(sw_abort), .cnt_load(cnt_load),
      .cnt_value(cnt_value), .irq_ack(irq_ack), .drq(drq), .drq_oe(drq_oe),
      .irq(irq), .data_move(data_move)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_start();
      sw_start = 1; step(); sw_start = 0;
   endtask

   task automatic load_cnt(input int v);
      cnt_value = CW'(v); cnt_load = 1; step(); cnt_load = 0;
   endtask

   // One byte: ready, request seen, acknowledge (with optional tc and ack)
   task automatic one_xfer(input bit last, input bit ack_too);
      xfer_ready = 1; step(); xfer_ready = 0;
      chk("R3 drq after ready", drq, 1);
      dack_n = 0; tc = last; irq_ack = ack_too;
      #1 chk("R4 data_move on valid ack", data_move, 1);
      step();
      dack_n = 1; tc = 0; irq_ack = 0;
      chk("R3 drq falls after ack", drq, 0);
   endtask

   task automatic clear_irq();
      irq_ack = 1; step(); irq_ack = 0;
      chk("R7 irq cleared by ack", irq, 0);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R1 drq reset", drq, 0);
      chk("R1 drq_oe reset", drq_oe, 0);
      chk("R1 irq reset", irq, 0);
      chk("R1 data_move reset", data_move, 0);
      rst_n = 1; step();

      // R2: idle ignores xfer_ready and keeps the line released
      xfer_ready = 1; step(); step(); xfer_ready = 0;
      chk("R2 idle drq", drq, 0);
      chk("R2 idle oe", drq_oe, 0);
      // R4/R5: stray ack with tc while idle
      dack_n = 0; tc = 1;
      #1 chk("R4 idle stray ack", data_move, 0);
      step(); dack_n = 1; tc = 0;
      chk("R5 idle tc ignored", irq, 0);

      // R2: start plus abort together, abort wins
      sw_start = 1; sw_abort = 1; step(); sw_start = 0; sw_abort = 0;
      chk("R2 abort beats start", drq_oe, 0);
      pulse_start();
      chk("R2 start arms", drq_oe, 1);
      // R4/R5: stray ack with tc while armed but no request pending
      dack_n = 0; tc = 1;
      #1 chk("R4 no-request ack", data_move, 0);
      step(); dack_n = 1; tc = 0;
      chk("R5 unmatched tc no irq", irq, 0);
      chk("R5 unmatched tc stays armed", drq_oe, 1);
      // R3: request held without acknowledge
      xfer_ready = 1; step(); xfer_ready = 0;
      step(); step(); step();
      chk("R3 drq held", drq, 1);
      // R2: abort drops request and enable
      sw_abort = 1; step(); sw_abort = 0;
      chk("R2 abort oe", drq_oe, 0);
      chk("R2 abort drq", drq, 0);

      // R6/R5 sweep over early count and buffer length
      for (int n = 0; n <= 6; n++) begin
         for (int len = 1; len <= 7; len++) begin
            int kexp;
            kexp = (n != 0 && n < len) ? n : len;
            load_cnt(n);
            pulse_start();
            for (int k = 1; k <= len; k++) begin
               one_xfer(k == len, 1'b0);
               if (n != 0 && k == n && n < len)
                  chk("R6 early irq", irq, 1);
               else if (k == len)
                  chk("R5 tc irq", irq, 1);
               else
                  chk("R6 no irq yet", irq, (k >= kexp) ? 1 : 0);
            end
            chk("R5 tc disarms", drq_oe, 0);
            clear_irq();
         end
      end

      // R7: set wins over a simultaneous acknowledge
      load_cnt(1);
      pulse_start();
      one_xfer(1'b0, 1'b0);
      chk("R7 early set", irq, 1);
      one_xfer(1'b1, 1'b1);
      chk("R7 set beats clear", irq, 1);
      clear_irq();
      step();
      chk("R7 stays clear", irq, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule